// File: doc/BRIEF.md
# Low-Power Scan Stimulus Generator

This block drives the scan-in pins of several scan chains during shift mode with pseudo-random stimulus, while keeping toggling inside each chain low. A 16-bit linear feedback shift register is the random source. A fixed XOR spreading network derives one fresh bit per chain from its state. Each chain owns a small transition controller: one flip-flop, one multiplexer and one equality gate.

The controller watches the two scan cells nearest the end of its own chain. If those two cells hold the same value, the controller's flip-flop takes the chain's fresh random bit on the next shift edge. If they differ, the flip-flop repeats the bit it sent last. The stimulus therefore follows the chain's own recent activity, and neighbouring scan cells are more often equal.

The random source can be given a seed at any time. A zero seed would lock the register, so it is replaced by a fixed nonzero constant. With scan enable low, everything freezes.

Top module: `lp_scan_stim`

## Requirements
- R1: After reset every scan_in_o bit is 0 and the random register holds 16'hACE1.
- R2: On a clock edge with shift_en_i high and seed_load_i low, the random register moves one place toward its MSB. Its new bit 0 is the XOR of its old bits 15, 13, 12 and 10.
- R3: The fresh bit of chain i is the XOR of the random register's bits (3i) mod 16, (3i+7) mod 16 and (3i+11) mod 16. The state used is the one before that edge's update.
- R4: With shift_en_i high and cell_prev_i[i] equal to cell_last_i[i], scan_in_o[i] takes chain i's fresh bit on the next edge.
- R5: With shift_en_i high and cell_prev_i[i] different from cell_last_i[i], scan_in_o[i] keeps its value on the next edge.
- R6: With shift_en_i low, scan_in_o keeps its value whatever the cell inputs are. With seed_load_i also low, the random register keeps its value too.
- R7: With seed_load_i high, the random register takes seed_i on the next edge whether or not shift_en_i is high. No advance happens on that edge.
- R8: A seed of zero loads 16'hACE1 in its place, so the random register is never all zeros.
- R9: When seed_load_i and shift_en_i are high on the same edge, the controllers use the fresh bits of the state held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load seed_i into the random register on this edge |
| seed_i | input | LFSR_W | Seed value |
| shift_en_i | input | 1 | Scan shift mode enable |
| cell_prev_i | input | NUM_CHAINS | Second-to-last cell of each chain |
| cell_last_i | input | NUM_CHAINS | Last cell of each chain |
| scan_in_o | output | NUM_CHAINS | Scan-in bit driven into each chain |

## Verification
The two functions that can fall in the same cycle are the seed load and a shift. On that edge the register is overwritten instead of advanced, while the controllers still take fresh bits from the old state. The bench provokes this with shift and load both high, using zero and nonzero seeds and with the chains' cell pairs equal. A behavioural model advances a plain integer and recomputes each chain's taps. Every output bit is compared with the model on every cycle, so a controller that saw the loaded state shows up as a mismatch in the next cycle.

// File: rtl/lp_stim_pkg.sv
package lp_stim_pkg;

    localparam int unsigned SPREAD_FANIN = 3;

    // Offset of spreading tap k for any chain; the three offsets are distinct modulo 16.
    function automatic int unsigned spread_offset(input int unsigned k);
        case (k)
            0:       return 0;
            1:       return 7;
            default: return 11;
        endcase
    endfunction

    // Register bit feeding tap k of chain c.
    function automatic int unsigned spread_tap(input int unsigned c,
                                               input int unsigned k,
                                               input int unsigned width);
        return (3 * c + spread_offset(k)) % width;
    endfunction

    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_HOLD = 2'd1,
        CTL_LOAD = 2'd2
    } ctl_act_e;

endpackage

// File: rtl/lp_stim_lfsr.sv
module lp_stim_lfsr #(
    parameter int unsigned          W        = 16,
    parameter logic [W-1:0]         TAPS     = 16'hB400,
    parameter logic [W-1:0]         FALLBACK = 16'hACE1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         adv_i,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] state_o
);

    typedef struct packed {
        logic [W-1:0] state;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;
    logic     fb;

    always_comb begin
        st_d = st_q;
        fb   = ^(st_q.state & TAPS);
        if (load_i) begin
            st_d.state = (seed_i == '0) ? FALLBACK : seed_i;
        end else if (adv_i) begin
            st_d.state = {st_q.state[W-2:0], fb};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.state <= FALLBACK;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.state;

endmodule

// File: rtl/lp_stim_spread.sv
module lp_stim_spread #(
    parameter int unsigned W = 16,
    parameter int unsigned N = 4
) (
    input  logic [W-1:0] state_i,
    output logic [N-1:0] fresh_o
);

    for (genvar c = 0; c < N; c++) begin : g_chain
        logic [lp_stim_pkg::SPREAD_FANIN-1:0] picked;
        for (genvar k = 0; k < lp_stim_pkg::SPREAD_FANIN; k++) begin : g_tap
            localparam int unsigned TAP = lp_stim_pkg::spread_tap(c, k, W);
            assign picked[k] = state_i[TAP];
        end
        assign fresh_o[c] = ^picked;
    end

endmodule

// File: rtl/lp_stim_tctl.sv
module lp_stim_tctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic shift_en_i,
    input  logic cell_prev_i,
    input  logic cell_last_i,
    input  logic fresh_i,
    output logic scan_in_o
);

    import lp_stim_pkg::*;

    typedef struct packed {
        logic drive;
    } tctl_st_t;

    tctl_st_t st_d, st_q;
    ctl_act_e act;
    logic     same;

    always_comb begin
        same = cell_prev_i ~^ cell_last_i;
        if (!shift_en_i) begin
            act = CTL_IDLE;
        end else if (same) begin
            act = CTL_LOAD;
        end else begin
            act = CTL_HOLD;
        end
        st_d = st_q;
        if (act == CTL_LOAD) begin
            st_d.drive = fresh_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.drive <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_in_o = st_q.drive;

endmodule

// File: rtl/lp_scan_stim.sv
module lp_scan_stim #(
    parameter int unsigned          LFSR_W     = 16,
    parameter int unsigned          NUM_CHAINS = 4,
    parameter logic [LFSR_W-1:0]    TAPS       = 16'hB400,
    parameter logic [LFSR_W-1:0]    FALLBACK   = 16'hACE1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  seed_load_i,
    input  logic [LFSR_W-1:0]     seed_i,
    input  logic                  shift_en_i,
    input  logic [NUM_CHAINS-1:0] cell_prev_i,
    input  logic [NUM_CHAINS-1:0] cell_last_i,
    output logic [NUM_CHAINS-1:0] scan_in_o
);

    logic [LFSR_W-1:0]     lfsr_state;
    logic [NUM_CHAINS-1:0] fresh;

    lp_stim_lfsr #(
        .W        (LFSR_W),
        .TAPS     (TAPS),
        .FALLBACK (FALLBACK)
    ) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .adv_i   (shift_en_i),
        .load_i  (seed_load_i),
        .seed_i  (seed_i),
        .state_o (lfsr_state)
    );

    lp_stim_spread #(
        .W (LFSR_W),
        .N (NUM_CHAINS)
    ) u_spread (
        .state_i (lfsr_state),
        .fresh_o (fresh)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_ctl
        lp_stim_tctl u_tctl (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .shift_en_i  (shift_en_i),
            .cell_prev_i (cell_prev_i[c]),
            .cell_last_i (cell_last_i[c]),
            .fresh_i     (fresh[c]),
            .scan_in_o   (scan_in_o[c])
        );
    end

endmodule

// File: rtl/lp_scan_stim_chk.sv
module lp_scan_stim_chk #(
    parameter int unsigned          LFSR_W     = 16,
    parameter int unsigned          NUM_CHAINS = 4,
    parameter logic [LFSR_W-1:0]    TAPS       = 16'hB400,
    parameter logic [LFSR_W-1:0]    FALLBACK   = 16'hACE1
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  seed_load_i,
    input logic [LFSR_W-1:0]     seed_i,
    input logic                  shift_en_i,
    input logic [NUM_CHAINS-1:0] cell_prev_i,
    input logic [NUM_CHAINS-1:0] cell_last_i,
    input logic [NUM_CHAINS-1:0] scan_in_o,
    input logic [LFSR_W-1:0]     lfsr_state_i
);

    p_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_en_i && !seed_load_i) |=>
            lfsr_state_i == {$past(lfsr_state_i[LFSR_W-2:0]), ^($past(lfsr_state_i) & TAPS)});

    p_differ_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_en_i |=>
            ((scan_in_o ^ $past(scan_in_o)) & $past(cell_prev_i ^ cell_last_i)) == '0);

    p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_en_i |=> $stable(scan_in_o));

    p_idle_lfsr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shift_en_i && !seed_load_i) |=> $stable(lfsr_state_i));

    p_seed_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seed_load_i && seed_i != '0) |=> lfsr_state_i == $past(seed_i));

    p_zero_seed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seed_load_i && seed_i == '0) |=> lfsr_state_i == FALLBACK);

    p_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_state_i != '0);

endmodule

bind lp_scan_stim lp_scan_stim_chk #(
    .LFSR_W     (LFSR_W),
    .NUM_CHAINS (NUM_CHAINS),
    .TAPS       (TAPS),
    .FALLBACK   (FALLBACK)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .seed_load_i  (seed_load_i),
    .seed_i       (seed_i),
    .shift_en_i   (shift_en_i),
    .cell_prev_i  (cell_prev_i),
    .cell_last_i  (cell_last_i),
    .scan_in_o    (scan_in_o),
    .lfsr_state_i (lfsr_state)
);

// File: tb/lp_scan_stim_bench.sv
module lp_scan_stim_bench;

    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld = 1'b0;
    logic [15:0]   sd = '0;
    logic          se = 1'b0;
    logic [NC-1:0] pv = '0;
    logic [NC-1:0] lt = '0;
    logic [NC-1:0] so;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // Reference model state
    int    m_reg;
    bit    m_out [NC];
    string m_tag [NC];
    string seed_tag = "R2,R3,R4";

    always #2 clk = ~clk;

    lp_scan_stim u_lp_scan_stim (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .seed_load_i (ld),
        .seed_i      (sd),
        .shift_en_i  (se),
        .cell_prev_i (pv),
        .cell_last_i (lt),
        .scan_in_o   (so)
    );

    function automatic bit reg_bit(input int r, input int b);
        return bit'((r >> b) & 1);
    endfunction

    function automatic bit fresh_of(input int r, input int c);
        return reg_bit(r, (3*c) % 16) ^ reg_bit(r, (3*c + 7) % 16) ^ reg_bit(r, (3*c + 11) % 16);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = 'hACE1;
            for (int c = 0; c < NC; c++) begin
                m_out[c] = 1'b0;
                m_tag[c] = "R1";
            end
        end else begin
            int nxt;
            nxt = m_reg;
            for (int c = 0; c < NC; c++) begin
                if (!se) begin
                    m_tag[c] = "R6";
                end else if (pv[c] == lt[c]) begin
                    m_out[c] = fresh_of(m_reg, c);
                    m_tag[c] = ld ? "R9" : seed_tag;
                end else begin
                    m_tag[c] = "R5";
                end
            end
            if (ld) begin
                nxt = (sd == 16'h0) ? 'hACE1 : int'(sd);
                seed_tag = (sd == 16'h0) ? "R8" : "R7";
            end else if (se) begin
                nxt = ((m_reg << 1) & 'hFFFF) |
                      int'(reg_bit(m_reg, 15) ^ reg_bit(m_reg, 13) ^ reg_bit(m_reg, 12) ^ reg_bit(m_reg, 10));
            end
            m_reg = nxt;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NC; c++) begin
                checks++;
                if (so[c] !== m_out[c]) begin
                    errors++;
                    $display("FAIL %s chain %0d actual %0b expected %0b", m_tag[c], c, so[c], m_out[c]);
                end
            end
        end
    end

    task automatic drive(input bit s, input bit l, input logic [15:0] seed,
                         input logic [NC-1:0] p, input logic [NC-1:0] q);
        @(negedge clk);
        se = s; ld = l; sd = seed; pv = p; lt = q;
    endtask

    task automatic run_random(input int n, input bit s, input int load_odds);
        for (int i = 0; i < n; i++) begin
            bit l;
            l = (load_odds > 0) && ($urandom % load_odds == 0);
            drive(s, l, ($urandom % 8 == 0) ? 16'h0 : 16'($urandom),
                  NC'($urandom), NC'($urandom));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (so !== '0) begin
            errors++;
            $display("FAIL R1 reset output actual %b expected %b", so, {NC{1'b0}});
        end
        // R6: idle with wild cell inputs
        run_random(20, 1'b0, 0);
        // R2 R3 R4: every chain loads fresh bits
        for (int i = 0; i < 100; i++) begin
            logic [NC-1:0] v;
            v = NC'($urandom);
            drive(1'b1, 1'b0, 16'h0, v, v);
        end
        // Mixed patterns
        run_random(300, 1'b1, 0);
        // R5: every chain disagrees
        for (int i = 0; i < 30; i++) begin
            logic [NC-1:0] v;
            v = NC'($urandom);
            drive(1'b1, 1'b0, 16'h0, v, ~v);
        end
        // R7: load while idle, then shift
        drive(1'b0, 1'b1, 16'h1234, '0, '0);
        run_random(40, 1'b1, 0);
        // R8 with R9: zero seed during shift, equal cells
        drive(1'b1, 1'b1, 16'h0, '1, '1);
        for (int i = 0; i < 40; i++) drive(1'b1, 1'b0, 16'h0, '0, '0);
        // R9: nonzero seed during shift, equal cells
        drive(1'b1, 1'b1, 16'h8001, '0, '0);
        drive(1'b1, 1'b1, 16'h7FFE, '1, '1);
        for (int i = 0; i < 40; i++) drive(1'b1, 1'b0, 16'h0, '1, '1);
        // Zero seed while idle
        drive(1'b0, 1'b1, 16'h0, '0, '1);
        run_random(10, 1'b0, 0);
        for (int i = 0; i < 30; i++) drive(1'b1, 1'b0, 16'h0, '0, '0);
        // Long mixed run with occasional loads and idle gaps
        for (int b = 0; b < 30; b++) begin
            run_random(100, 1'b1, 64);
            run_random(5, 1'b0, 4);
        end
        drive(1'b0, 1'b0, 16'h0, '0, '0);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule